// File: doc/BRIEF.md
# Console Operation Dispatcher

This block sits between the operator console and the processor's control sequencer. Each manual request from the console is folded into one 4-bit operation code: the single-step start, setting the instruction counter, repeating an instruction, and displaying or storing a storage location. A short idle sequence, the halt loop, then decodes that code into the index of the service routine to run. The same decode path serves every console request, so no request needs its own control logic.

The code is accepted only while the block idles in the halt loop. After a dispatch cycle the selected routine either finishes at once or waits for an instruction-complete strobe from the execution side. Memory access, instruction execution and interrupt handling are outside the block. The block drives the stop and manual trigger levels, an exception-branch request, and load strobes for the instruction address register and the storage address register.

Top module: `opctl_dispatch`

## Requirements
- R1: A request is accepted only in the halt loop. A request that arrives while a routine is dispatching or waiting on instruction completion is dropped. It changes neither the code nor the routine, and it is not taken up later.
- R2: When several requests arrive in one cycle, the order of precedence is set-counter, then repeat, then store, then display, then start.
- R3: With step mode on and the wait bit clear, a start pulse loads code 0x1 (only the lowest code bit) and selects routine 151. With the wait bit set, or in process mode, start loads no code.
- R4: In the step routine's dispatch cycle, the storage address register loads with sar_sel_keys = 0. From the next cycle the stop trigger is off, and it stays off until instr_done. The cycle after instr_done, the block is back in the halt loop with code 0 and the stop trigger on.
- R5: Set-counter loads code 0x2 and selects routine 152. It pulses iar_load for its one dispatch cycle and keeps the stop trigger on. The next cycle it is back in the halt loop with code 0.
- R6: Repeat loads code 0x3 and selects routine 153. It pulses sar_load with sar_sel_keys = 1 and keeps the stop trigger on. When instr_done arrives while repeat_sw is still high, the block dispatches routine 153 again. Otherwise it returns to the halt loop with code 0.
- R7: Display and store both set code bit 3. Store also sets bit 0. Bits 2:1 carry the storage area (main 00, local 01, protect 10, bump 11), so display is 0x8 + 2·area and store is 0x9 + 2·area. These codes select routine 220 for one cycle, then the block returns to the halt loop.
- R8: exc_branch is registered. One cycle after step mode is on, or after acmp_mode is nonzero, it is 1. Otherwise it is 0 one cycle later.
- R9: The manual trigger is 1 one cycle after step mode is on. A start pulse in the halt loop with process mode and the wait bit clear turns it off from the next cycle.
- R10: After reset, the code is 0, the routine is 150, the stop and manual triggers are 1, and exc_branch, iar_load, sar_load and sar_sel_keys are 0.
- R11: The routine index follows the code register in the same cycle: code 0 gives 150, 0x1 gives 151, 0x2 gives 152, 0x3 gives 153, and any code with bit 3 set gives 220.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_mode | input | 1 | Rate switch: 1 = instruction step, 0 = process |
| start_pb | input | 1 | Start pushbutton, one-cycle pulse |
| setic_pb | input | 1 | Set instruction counter pushbutton, one-cycle pulse |
| repeat_sw | input | 1 | Repeat-instruction lever, level |
| display_pb | input | 1 | Display pushbutton, one-cycle pulse |
| store_pb | input | 1 | Store pushbutton, one-cycle pulse |
| area_sel | input | 2 | Storage area: 00 main, 01 local, 10 protect, 11 bump |
| acmp_mode | input | 2 | Address compare: 00 off, any other value active |
| wait_bit | input | 1 | Wait state bit from the status word |
| instr_done | input | 1 | Instruction (and interrupts) complete, one-cycle pulse |
| status | output | 4 | Operation code register |
| routine | output | RTN_W | Selected service routine index |
| stop_trig | output | 1 | Stop trigger level |
| man_trig | output | 1 | Manual trigger level |
| exc_branch | output | 1 | Exception-branch request |
| iar_load | output | 1 | Load address keys into instruction address register |
| sar_load | output | 1 | Load storage address register and start a fetch |
| sar_sel_keys | output | 1 | Storage address source: 1 = address keys, 0 = instruction address |

## Verification
A request pulsed in one cycle shows its code and routine, together with any load strobe, after exactly one clock edge. The return to the halt loop, with code 0, shows after the next edge for set-counter and storage requests. For step and repeat it shows one edge after instr_done. The trigger levels and exc_branch change one edge after their cause. The bench drives inputs on the falling edge and samples on the following falling edge, so each sample sees the effect of exactly one rising edge. It walks the routines cycle by cycle against those counts while sweeping every request combination, storage area and wait-bit value in step mode.

// File: rtl/opctl_pkg.sv
package opctl_pkg;

   typedef enum logic [1:0] {
      PH_HALT = 2'd0,
      PH_DISP = 2'd1,
      PH_RUN  = 2'd2
   } phase_e;

   localparam int CODE_W = 4;

   localparam logic [CODE_W-1:0] OP_NONE   = 4'h0;
   localparam logic [CODE_W-1:0] OP_STEP   = 4'h1;
   localparam logic [CODE_W-1:0] OP_SETIC  = 4'h2;
   localparam logic [CODE_W-1:0] OP_REPEAT = 4'h3;

   // bit 3: storage access, bit 0: write, bits 2:1: storage area
   localparam int BIT_STORAGE = 3;
   localparam int BIT_WRITE   = 0;

   typedef struct packed {
      logic              valid;
      logic [CODE_W-1:0] code;
   } req_t;

endpackage

// File: rtl/opctl_req_enc.sv
module opctl_req_enc
   import opctl_pkg::*;
(
   input  logic       step_mode,
   input  logic       wait_bit,
   input  logic       start_pb,
   input  logic       setic_pb,
   input  logic       repeat_sw,
   input  logic       display_pb,
   input  logic       store_pb,
   input  logic [1:0] area_sel,
   output req_t       req
);

   logic step_ok;
   logic [CODE_W-1:0] mem_code;

   assign step_ok = start_pb & step_mode & ~wait_bit;

   always_comb begin
      mem_code = '0;
      mem_code[BIT_STORAGE] = 1'b1;
      mem_code[2:1] = area_sel;
      mem_code[BIT_WRITE] = store_pb;
   end

   always_comb begin
      req = '0;
      if (setic_pb) begin
         req.valid = 1'b1;
         req.code  = OP_SETIC;
      end else if (repeat_sw) begin
         req.valid = 1'b1;
         req.code  = OP_REPEAT;
      end else if (store_pb || display_pb) begin
         req.valid = 1'b1;
         req.code  = mem_code;
      end else if (step_ok) begin
         req.valid = 1'b1;
         req.code  = OP_STEP;
      end
   end

endmodule

// File: rtl/opctl_route_dec.sv
module opctl_route_dec
   import opctl_pkg::*;
#(
   parameter int RTN_W       = 8,
   parameter int RTN_HALT    = 150,
   parameter int RTN_STEP    = 151,
   parameter int RTN_SETIC   = 152,
   parameter int RTN_REPEAT  = 153,
   parameter int RTN_STORAGE = 220
)(
   input  logic [CODE_W-1:0] code,
   output logic [RTN_W-1:0]  routine
);

   localparam int N_CTL = 3;

   logic [N_CTL-1:0] hit;

   // control codes 1..N_CTL map to consecutive routine slots
   for (genvar g = 0; g < N_CTL; g++) begin : g_hit
      assign hit[g] = (code == CODE_W'(g + 1));
   end

   always_comb begin
      routine = RTN_W'(RTN_HALT);
      if (code[BIT_STORAGE])
         routine = RTN_W'(RTN_STORAGE);
      else if (hit[0])
         routine = RTN_W'(RTN_STEP);
      else if (hit[1])
         routine = RTN_W'(RTN_SETIC);
      else if (hit[2])
         routine = RTN_W'(RTN_REPEAT);
   end

endmodule

// File: rtl/opctl_seq.sv
module opctl_seq
   import opctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  req_t              req,
   input  logic              step_mode,
   input  logic [1:0]        acmp_mode,
   input  logic              wait_bit,
   input  logic              start_pb,
   input  logic              repeat_sw,
   input  logic              instr_done,
   output phase_e            phase,
   output logic [CODE_W-1:0] status,
   output logic              stop_trig,
   output logic              man_trig,
   output logic              exc_branch,
   output logic              iar_load,
   output logic              sar_load,
   output logic              sar_sel_keys
);

   logic in_disp;

   assign in_disp = (phase == PH_DISP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_HALT;
         status     <= OP_NONE;
         stop_trig  <= 1'b1;
         man_trig   <= 1'b1;
         exc_branch <= 1'b0;
      end else begin
         exc_branch <= step_mode | (acmp_mode != 2'b00);

         if (step_mode)
            man_trig <= 1'b1;
         else if (phase == PH_HALT && start_pb && !wait_bit)
            man_trig <= 1'b0;

         unique case (phase)
            PH_HALT: begin
               if (req.valid) begin
                  status <= req.code;
                  phase  <= PH_DISP;
               end
            end
            PH_DISP: begin
               if (status == OP_STEP) begin
                  stop_trig <= 1'b0;
                  phase     <= PH_RUN;
               end else if (status == OP_REPEAT) begin
                  stop_trig <= 1'b1;
                  phase     <= PH_RUN;
               end else begin
                  stop_trig <= 1'b1;
                  status    <= OP_NONE;
                  phase     <= PH_HALT;
               end
            end
            PH_RUN: begin
               if (instr_done) begin
                  if (status == OP_REPEAT && repeat_sw) begin
                     phase <= PH_DISP;
                  end else begin
                     status    <= OP_NONE;
                     stop_trig <= 1'b1;
                     phase     <= PH_HALT;
                  end
               end
            end
            default: phase <= PH_HALT;
         endcase
      end
   end

   assign iar_load     = in_disp && (status == OP_SETIC);
   assign sar_load     = in_disp && (status == OP_STEP || status == OP_REPEAT);
   assign sar_sel_keys = in_disp && (status == OP_REPEAT);

endmodule

// File: rtl/opctl_dispatch.sv
module opctl_dispatch
   import opctl_pkg::*;
#(
   parameter int RTN_W       = 8,
   parameter int RTN_HALT    = 150,
   parameter int RTN_STEP    = 151,
   parameter int RTN_SETIC   = 152,
   parameter int RTN_REPEAT  = 153,
   parameter int RTN_STORAGE = 220
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_mode,
   input  logic             start_pb,
   input  logic             setic_pb,
   input  logic             repeat_sw,
   input  logic             display_pb,
   input  logic             store_pb,
   input  logic [1:0]       area_sel,
   input  logic [1:0]       acmp_mode,
   input  logic             wait_bit,
   input  logic             instr_done,
   output logic [3:0]       status,
   output logic [RTN_W-1:0] routine,
   output logic             stop_trig,
   output logic             man_trig,
   output logic             exc_branch,
   output logic             iar_load,
   output logic             sar_load,
   output logic             sar_sel_keys
);

   localparam int RTN_LIMIT = 1 << RTN_W;

   if (RTN_W < 1 || RTN_W > 16) begin : g_bad_w
      $error("opctl_dispatch: RTN_W out of range");
   end
   if (RTN_HALT >= RTN_LIMIT || RTN_STEP >= RTN_LIMIT || RTN_SETIC >= RTN_LIMIT ||
       RTN_REPEAT >= RTN_LIMIT || RTN_STORAGE >= RTN_LIMIT) begin : g_bad_rtn
      $error("opctl_dispatch: routine index does not fit RTN_W");
   end
   if (RTN_HALT == RTN_STEP || RTN_HALT == RTN_SETIC || RTN_HALT == RTN_REPEAT ||
       RTN_HALT == RTN_STORAGE || RTN_STEP == RTN_SETIC || RTN_STEP == RTN_REPEAT ||
       RTN_SETIC == RTN_REPEAT) begin : g_bad_dup
      $error("opctl_dispatch: routine indices must be distinct");
   end

   req_t   req;
   phase_e phase;

   opctl_req_enc u_enc (
      .step_mode  (step_mode),
      .wait_bit   (wait_bit),
      .start_pb   (start_pb),
      .setic_pb   (setic_pb),
      .repeat_sw  (repeat_sw),
      .display_pb (display_pb),
      .store_pb   (store_pb),
      .area_sel   (area_sel),
      .req        (req)
   );

   opctl_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (req),
      .step_mode    (step_mode),
      .acmp_mode    (acmp_mode),
      .wait_bit     (wait_bit),
      .start_pb     (start_pb),
      .repeat_sw    (repeat_sw),
      .instr_done   (instr_done),
      .phase        (phase),
      .status       (status),
      .stop_trig    (stop_trig),
      .man_trig     (man_trig),
      .exc_branch   (exc_branch),
      .iar_load     (iar_load),
      .sar_load     (sar_load),
      .sar_sel_keys (sar_sel_keys)
   );

   opctl_route_dec #(
      .RTN_W       (RTN_W),
      .RTN_HALT    (RTN_HALT),
      .RTN_STEP    (RTN_STEP),
      .RTN_SETIC   (RTN_SETIC),
      .RTN_REPEAT  (RTN_REPEAT),
      .RTN_STORAGE (RTN_STORAGE)
   ) u_dec (
      .code    (status),
      .routine (routine)
   );

endmodule

// File: rtl/opctl_chk.sv
module opctl_chk
   import opctl_pkg::*;
#(
   parameter int RTN_W       = 8,
   parameter int RTN_STORAGE = 220
)(
   input logic             clk,
   input logic             rst_n,
   input phase_e           phase,
   input logic [3:0]       status,
   input logic [RTN_W-1:0] routine,
   input logic             step_mode,
   input logic [1:0]       acmp_mode,
   input logic             instr_done,
   input logic             stop_trig,
   input logic             exc_branch,
   input logic             iar_load,
   input logic             sar_load
);

   // R1: a code can only appear out of the halt loop
   a_r1_load_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 4'h0 && $past(status) == 4'h0) |-> $past(phase) == PH_HALT);

   // R4: stop trigger drops after the step dispatch
   a_r4_step_stop_off: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DISP && status == OP_STEP) |=> !stop_trig);

   // R4: stop trigger stays off while the stepped instruction runs
   a_r4_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RUN && status == OP_STEP && !instr_done) |=> !stop_trig);

   // R5: set-counter loads the instruction address only
   a_r5_setic_iar: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DISP && status == OP_SETIC) |-> (iar_load && !sar_load));

   // R5: set-counter returns to the halt loop next cycle
   a_r5_setic_return: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DISP && status == OP_SETIC) |=> (phase == PH_HALT && status == 4'h0 && stop_trig));

   // R6: the two register loads never coincide
   a_r6_load_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({iar_load, sar_load}));

   // R7: storage codes always select the storage routine
   a_r7_storage_rtn: assert property (@(posedge clk) disable iff (!rst_n)
      status[3] |-> routine == RTN_W'(RTN_STORAGE));

   // R8: exception branch follows step mode or address compare
   a_r8_exc_branch: assert property (@(posedge clk) disable iff (!rst_n)
      (step_mode || acmp_mode != 2'b00) |=> exc_branch);

endmodule

bind opctl_dispatch opctl_chk #(
   .RTN_W       (RTN_W),
   .RTN_STORAGE (RTN_STORAGE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .phase      (phase),
   .status     (status),
   .routine    (routine),
   .step_mode  (step_mode),
   .acmp_mode  (acmp_mode),
   .instr_done (instr_done),
   .stop_trig  (stop_trig),
   .exc_branch (exc_branch),
   .iar_load   (iar_load),
   .sar_load   (sar_load)
);

// File: tb/sim_opctl_dispatch.sv
module sim_opctl_dispatch;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_mode = 1'b0;
   logic       start_pb = 1'b0;
   logic       setic_pb = 1'b0;
   logic       repeat_sw = 1'b0;
   logic       display_pb = 1'b0;
   logic       store_pb = 1'b0;
   logic [1:0] area_sel = 2'b00;
   logic [1:0] acmp_mode = 2'b00;
   logic       wait_bit = 1'b0;
   logic       instr_done = 1'b0;
   logic [3:0] status;
   logic [7:0] routine;
   logic       stop_trig, man_trig, exc_branch, iar_load, sar_load, sar_sel_keys;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   opctl_dispatch u0 (
      .clk(clk), .rst_n(rst_n), .step_mode(step_mode), .start_pb(start_pb),
      .setic_pb(setic_pb), .repeat_sw(repeat_sw), .display_pb(display_pb),
      .store_pb(store_pb), .area_sel(area_sel), .acmp_mode(acmp_mode),
      .wait_bit(wait_bit), .instr_done(instr_done), .status(status),
      .routine(routine), .stop_trig(stop_trig), .man_trig(man_trig),
      .exc_branch(exc_branch), .iar_load(iar_load), .sar_load(sar_load),
      .sar_sel_keys(sar_sel_keys)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int rtn_of(input int code);
      if (code == 0) return 150;
      if (code == 1) return 151;
      if (code == 2) return 152;
      if (code == 3) return 153;
      if (code >= 8) return 220;
      return 150;
   endfunction

   task automatic clear_pulses();
      start_pb = 0; setic_pb = 0; display_pb = 0; store_pb = 0;
      repeat_sw = 0; instr_done = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk("R10 status", status, 0);
      chk("R10 routine", routine, 150);
      chk("R10 stop", stop_trig, 1);
      chk("R10 man", man_trig, 1);
      chk("R10 exc", exc_branch, 0);
      chk("R10 loads", {iar_load, sar_load, sar_sel_keys}, 0);

      // R8 exception branch
      chk("R8 idle", exc_branch, 0);
      for (int m = 1; m < 4; m++) begin
         acmp_mode = 2'(m);
         @(negedge clk);
         chk("R8 acmp on", exc_branch, 1);
         acmp_mode = 0;
         @(negedge clk);
         chk("R8 acmp off", exc_branch, 0);
      end

      // R9 / R3 process-mode start
      wait_bit = 1; start_pb = 1;
      @(negedge clk); clear_pulses();
      chk("R9 start wait set", man_trig, 1);
      chk("R3 proc start no code", status, 0);
      wait_bit = 0; start_pb = 1;
      @(negedge clk); clear_pulses();
      chk("R9 start clears man", man_trig, 0);
      chk("R3 proc start no code", status, 0);
      step_mode = 1;
      @(negedge clk);
      chk("R9 step sets man", man_trig, 1);
      chk("R8 step exc", exc_branch, 1);

      // R2 R3 R4 R5 R6 R7 R11: sweep in step mode
      for (int w = 0; w < 2; w++) begin
         for (int a = 0; a < 4; a++) begin
            for (int c = 0; c < 32; c++) begin
               int exp;
               if (c[0]) exp = 2;
               else if (c[1]) exp = 3;
               else if (c[3]) exp = 9 + 2 * a;
               else if (c[2]) exp = 8 + 2 * a;
               else if (c[4] && w == 0) exp = 1;
               else exp = 0;
               wait_bit = w[0]; area_sel = 2'(a);
               setic_pb = c[0]; repeat_sw = c[1]; display_pb = c[2];
               store_pb = c[3]; start_pb = c[4];
               @(negedge clk); clear_pulses();
               chk("R2 code", status, exp);
               chk("R11 routine", routine, rtn_of(exp));
               chk("R5 iar_load", iar_load, exp == 2 ? 1 : 0);
               chk("R4 sar_load", sar_load, (exp == 1 || exp == 3) ? 1 : 0);
               chk("R6 sel keys", sar_sel_keys, exp == 3 ? 1 : 0);
               if (exp == 1 || exp == 3) begin
                  @(negedge clk);
                  chk(exp == 1 ? "R4 stop off" : "R6 stop on", stop_trig, exp == 1 ? 0 : 1);
                  chk("R4 run code held", status, exp);
                  chk("R4 no load in run", sar_load, 0);
                  instr_done = 1;
               end
               if (exp != 0) begin
                  @(negedge clk); clear_pulses();
                  chk("R7 return code", status, 0);
                  chk("R11 halt routine", routine, 150);
                  chk("R4 stop back on", stop_trig, 1);
               end
            end
         end
      end
      wait_bit = 0;

      // R1: requests during a running step are dropped
      start_pb = 1;
      @(negedge clk); clear_pulses();
      chk("R3 step code", status, 1);
      @(negedge clk);
      setic_pb = 1; display_pb = 1;
      @(negedge clk); clear_pulses();
      chk("R1 ignored code", status, 1);
      chk("R1 ignored routine", routine, 151);
      chk("R1 no iar", iar_load, 0);
      instr_done = 1;
      @(negedge clk); clear_pulses();
      chk("R4 back to halt", status, 0);
      @(negedge clk);
      chk("R1 not latched", status, 0);

      // R6: repeat held re-dispatches
      repeat_sw = 1;
      @(negedge clk);
      chk("R6 code", status, 3);
      @(negedge clk);
      chk("R6 run", sar_load, 0);
      instr_done = 1;
      @(negedge clk); instr_done = 0;
      chk("R6 redispatch load", sar_load, 1);
      chk("R6 redispatch keys", sar_sel_keys, 1);
      chk("R6 redispatch routine", routine, 153);
      repeat_sw = 0;
      @(negedge clk);
      instr_done = 1;
      @(negedge clk); instr_done = 0;
      chk("R6 release halt", status, 0);
      chk("R6 release stop", stop_trig, 1);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule